// File: doc/BRIEF.md
# Banked GPIO Data/Direction Port

This block is a general-purpose I/O port of up to fifty pins that software reaches through 16-bit registers on a simple request/response bus. Each pin has an output latch and a direction bit. The pins are grouped into four banks of sixteen, and pin n uses bit n mod 16 of its bank's registers. A read of a data register returns, for each pin, the latch value if the pin is an output, or the synchronized pad level if it is an input. The latch keeps its value while a pin is an input, so software can load the value first and then turn the pin into an output.

Two layouts are built from one parameter. In the combined layout (`SEPARATE_OE=0`), pins 32..47 are output-only. The direction of pins 48 and 49 sits in bits 8 and 9 of the top data register, next to their data bits. In the separate layout (`SEPARATE_OE=1`), every bank has its own direction register. `NUM_PINS` selects 36, 48 or 50 pins, and any bit position at or beyond that count has no effect.

Requests are accepted in every cycle, so there is no back-pressure on requests. A read is answered by `rsp_valid` with `rsp_data` exactly one cycle later. There is no ready signal on the response side, so the consumer must take each response in the cycle it is presented.

Top module: `gpio_port`

Register map (byte offsets; all other offsets, including odd ones, are unmapped):

| Offset | Content |
|---|---|
| 0x00 | direction, pins 0..15 |
| 0x02 | direction, pins 16..31 |
| 0x04 | data, pins 0..15 |
| 0x06 | data, pins 16..31 |
| 0x08 | direction, pins 32..47 (separate layout only) |
| 0x0A | direction, pins 48.. (separate layout only) |
| 0x1C | data, pins 32..47 |
| 0x1E | data, pins 48.. in bits 0..; combined layout: direction of pins 48/49 in bits 8/9 |

## Requirements
- R1: After reset, every output latch and every direction bit is 0, `rsp_valid` is 0, and `pin_oe` is 0 for all pins. The one exception is the combined layout, where pins 32..47 are output-only and so have `pin_oe`=1.
- R2: A write to 0x00 or 0x02 sets the direction of pins 0..15 or 16..31 (1 = output, 0 = input) from the next cycle on. A read of those offsets returns the direction bits.
- R3: A write to 0x04, 0x06, 0x1C or 0x1E loads the output latches of that bank, and `pin_out` shows the new value from the cycle after the write.
- R4: A read of a data register returns the latch for each output pin and, for each input pin, the pad level delayed through `SYNC_STAGES` flops.
- R5: The output latch keeps its value while its pin is an input. Switching the pin to output drives the value that was written earlier.
- R6: In the combined layout, bits 8 and 9 written to 0x1E set the direction of pins 48 and 49, and a read of 0x1E returns them in bits 8 and 9. These two bits never act as data for pins 56 and 57.
- R7: In the separate layout, 0x08 and 0x0A hold the direction of pins 32..47 and 48 onward. Bits 8 and 9 of 0x1E then have no effect and read as 0.
- R8: Bits for pins at or beyond `NUM_PINS` ignore writes and read as 0. Unmapped offsets read as 0 and writes to them change nothing.
- R9: `rsp_valid` is 1 exactly in the cycle after each read request and 0 in all other cycles. A write produces no response.
- R10: `pin_out` always equals the latches, and `pin_oe` always equals the effective direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request present this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | byte offset of the register |
| req_wdata | input | 16 | write data |
| rsp_valid | output | 1 | read data valid, one cycle after the read |
| rsp_data | output | 16 | read data |
| pin_in | input | NUM_PINS | pad input levels (asynchronous) |
| pin_out | output | NUM_PINS | output latch values |
| pin_oe | output | NUM_PINS | output enables (1 = drive) |

## Verification
The bench builds three copies side by side on one shared request bus. The first has 50 pins in the combined layout, which exercises the data/direction sharing at 0x1E and the output-only middle bank. The second has 50 pins in the separate layout, which exercises the direction registers at 0x08 and 0x0A and shows that bits 8/9 of 0x1E are ignored there. The third has 36 pins in the combined layout, which leaves a partial third bank and an empty fourth, so the bits beyond the pin count can be checked.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int NBANK  = 4;
  localparam int PADW   = NBANK * DATA_W;

  typedef enum logic [1:0] {
    DIR_REG       = 2'd0,
    DIR_FIXED_OUT = 2'd1,
    DIR_IN_DATA   = 2'd2
  } dir_mode_e;

  function automatic int bank_width(input int npins, input int b);
    int w;
    w = npins - b * DATA_W;
    if (w < 0) w = 0;
    if (w > DATA_W) w = DATA_W;
    return w;
  endfunction

  function automatic dir_mode_e bank_mode(input int b, input bit sep);
    if (b < 2 || sep) return DIR_REG;
    if (b == 2) return DIR_FIXED_OUT;
    return DIR_IN_DATA;
  endfunction

  function automatic logic [ADDR_W-1:0] data_addr(input int b);
    case (b)
      0: return 5'h04;
      1: return 5'h06;
      2: return 5'h1C;
      default: return 5'h1E;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] dir_addr(input int b);
    return 5'(2 * ((b < 2) ? b : b + 2));
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int        W    = 16,
  parameter dir_mode_e MODE = DIR_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_we,
  input  logic              dir_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pad_sync,
  output logic [DATA_W-1:0] out_o,
  output logic [DATA_W-1:0] oe_o,
  output logic [DATA_W-1:0] dat_rd,
  output logic [DATA_W-1:0] dir_rd
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'((33'd1 << W) - 33'd1);

  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] dir_in_data;

  assign dir_in_data = (wdata >> 8) & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (dat_we) out_q <= wdata & MASK;
      if (MODE == DIR_REG && dir_we)           dir_q <= wdata & MASK;
      else if (MODE == DIR_IN_DATA && dat_we) dir_q <= dir_in_data;
    end
  end

  assign out_o  = out_q;
  assign oe_o   = (MODE == DIR_FIXED_OUT) ? MASK : dir_q;
  assign dir_rd = dir_q;

  always_comb begin
    dat_rd = ((oe_o & out_q) | (~oe_o & pad_sync)) & MASK;
    if (MODE == DIR_IN_DATA) dat_rd = dat_rd | (dir_q << 8);
  end

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(out_o));

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_we && !dat_we) |=> $stable(oe_o));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 50,
  parameter bit SEPARATE_OE = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  logic [PADW-1:0]   pad_raw;
  logic [PADW-1:0]   pad_sync;
  logic [PADW-1:0]   out_all;
  logic [PADW-1:0]   oe_all;
  logic [DATA_W-1:0] dat_rd [NBANK];
  logic [DATA_W-1:0] dir_rd [NBANK];
  logic [NBANK-1:0]  dat_we;
  logic [NBANK-1:0]  dir_we;
  logic [DATA_W-1:0] rd_mux;
  logic              addr_hit;
  logic              wr_req;
  logic              rd_req;

  assign wr_req  = req_valid && req_write;
  assign rd_req  = req_valid && !req_write;
  assign pad_raw = PADW'(pin_in);

  gpio_sync #(.WIDTH(PADW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_raw),
    .d_out (pad_sync)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam int        BW = bank_width(NUM_PINS, b);
      localparam dir_mode_e BM = bank_mode(b, SEPARATE_OE);

      assign dat_we[b] = wr_req && (req_addr == data_addr(b));
      assign dir_we[b] = wr_req && (BM == DIR_REG) && (req_addr == dir_addr(b));

      gpio_bank #(.W(BW), .MODE(BM)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .dat_we   (dat_we[b]),
        .dir_we   (dir_we[b]),
        .wdata    (req_wdata),
        .pad_sync (pad_sync[b*DATA_W +: DATA_W]),
        .out_o    (out_all[b*DATA_W +: DATA_W]),
        .oe_o     (oe_all[b*DATA_W +: DATA_W]),
        .dat_rd   (dat_rd[b]),
        .dir_rd   (dir_rd[b])
      );
    end
  endgenerate

  always_comb begin
    rd_mux   = '0;
    addr_hit = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (req_addr == data_addr(b)) begin
        rd_mux   = dat_rd[b];
        addr_hit = 1'b1;
      end
      if (bank_mode(b, SEPARATE_OE) == DIR_REG && req_addr == dir_addr(b)) begin
        rd_mux   = dir_rd[b];
        addr_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_data  <= rd_req ? rd_mux : '0;
    end
  end

  assign pin_out = out_all[NUM_PINS-1:0];
  assign pin_oe  = oe_all[NUM_PINS-1:0];

  // R9
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  // R9
  no_rsp_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !addr_hit) |=> (rsp_data == '0));
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int N0 = 50;
  localparam int N1 = 50;
  localparam int N2 = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;

  logic        rv [3];
  logic [15:0] rd [3];
  logic [N0-1:0] pi0, po0, pe0;
  logic [N1-1:0] pi1, po1, pe1;
  logic [N2-1:0] pi2, po2, pe2;

  logic [63:0] m_out [3];
  logic [63:0] m_dir [3];
  logic [63:0] m_pin [3];

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  gpio_port #(.NUM_PINS(N0), .SEPARATE_OE(1'b0), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[0]), .rsp_data(rd[0]),
    .pin_in(pi0), .pin_out(po0), .pin_oe(pe0));

  gpio_port #(.NUM_PINS(N1), .SEPARATE_OE(1'b1), .SYNC_STAGES(2)) dut_sep (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[1]), .rsp_data(rd[1]),
    .pin_in(pi1), .pin_out(po1), .pin_oe(pe1));

  gpio_port #(.NUM_PINS(N2), .SEPARATE_OE(1'b0), .SYNC_STAGES(2)) dut_small (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[2]), .rsp_data(rd[2]),
    .pin_in(pi2), .pin_out(po2), .pin_oe(pe2));

  assign pi0 = m_pin[0][N0-1:0];
  assign pi1 = m_pin[1][N1-1:0];
  assign pi2 = m_pin[2][N2-1:0];

  function automatic int np_of(input int i);
    return (i == 2) ? N2 : 50;
  endfunction

  function automatic bit sep_of(input int i);
    return (i == 1);
  endfunction

  function automatic logic [63:0] vmask(input int i);
    return (64'd1 << np_of(i)) - 64'd1;
  endfunction

  function automatic logic [63:0] eff_oe(input int i);
    logic [63:0] fixed;
    fixed = sep_of(i) ? 64'd0 : 64'h0000_FFFF_0000_0000;
    return (m_dir[i] | fixed) & vmask(i);
  endfunction

  function automatic logic [15:0] exp_read(input int i, input logic [4:0] a);
    logic [63:0] oe, val, d;
    oe  = eff_oe(i);
    d   = m_dir[i] & vmask(i);
    val = ((oe & m_out[i]) | (~oe & m_pin[i])) & vmask(i);
    case (a)
      5'h00: return d[15:0];
      5'h02: return d[31:16];
      5'h04: return val[15:0];
      5'h06: return val[31:16];
      5'h1C: return val[47:32];
      5'h1E: return val[63:48] | (sep_of(i) ? 16'h0 : {6'b0, d[49:48], 8'b0});
      5'h08: return sep_of(i) ? d[47:32] : 16'h0;
      5'h0A: return sep_of(i) ? d[63:48] : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00, 5'h02: return "R2";
      5'h04, 5'h06, 5'h1C: return "R4";
      5'h1E: return "R6";
      5'h08, 5'h0A: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_write(input logic [4:0] a, input logic [15:0] wd);
    for (int i = 0; i < 3; i++) begin
      case (a)
        5'h00: m_dir[i][15:0]  = wd;
        5'h02: m_dir[i][31:16] = wd;
        5'h04: m_out[i][15:0]  = wd;
        5'h06: m_out[i][31:16] = wd;
        5'h1C: m_out[i][47:32] = wd;
        5'h1E: begin
          m_out[i][63:48] = wd;
          if (!sep_of(i)) m_dir[i][49:48] = wd[9:8];
        end
        5'h08: if (sep_of(i)) m_dir[i][47:32] = wd;
        5'h0A: if (sep_of(i)) m_dir[i][63:48] = wd;
        default: ;
      endcase
      m_out[i] = m_out[i] & vmask(i);
      m_dir[i] = m_dir[i] & vmask(i);
    end
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp, input int inst);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s inst%0d got=%h exp=%h", tag, inst, got, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    check(tag, 64'(po0), m_out[0], 0);
    check(tag, 64'(po1), m_out[1], 1);
    check(tag, 64'(po2), m_out[2], 2);
    check("R10", 64'(pe0), eff_oe(0), 0);
    check("R10", 64'(pe1), eff_oe(1), 1);
    check("R10", 64'(pe2), eff_oe(2), 2);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] wd, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, wd);
    for (int i = 0; i < 3; i++) check("R9", 64'(rv[i]), 64'd0, i);
    check_pins(tag);
  endtask

  task automatic bus_read(input logic [4:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R9", 64'(rv[i]), 64'd1, i);
      check(tag, 64'(rd[i]), 64'(exp_read(i, a)), i);
    end
  endtask

  task automatic set_pins(input logic [63:0] v0, input logic [63:0] v1, input logic [63:0] v2);
    @(negedge clk);
    m_pin[0] = v0; m_pin[1] = v1; m_pin[2] = v2;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin m_out[i] = '0; m_dir[i] = '0; m_pin[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of latches, enables and the response flag
    check_pins("R1");
    for (int i = 0; i < 3; i++) check("R1", 64'(rv[i]), 64'd0, i);
    bus_read(5'h00, "R1");
    bus_read(5'h1E, "R1");

    // R5: latch loaded while input, then driven on switch to output
    set_pins(64'h5A5A, 64'h5A5A, 64'h5A5A);
    bus_write(5'h04, 16'hA5A5, "R3");
    bus_read(5'h04, "R5");
    bus_write(5'h00, 16'hFFFF, "R5");
    bus_read(5'h04, "R5");
    bus_write(5'h00, 16'h00F0, "R2");
    bus_read(5'h04, "R4");

    // R6 / R7: bits 8/9 of the top data register
    bus_write(5'h1E, 16'h0302, "R6");
    bus_read(5'h1E, "R6");
    bus_write(5'h0A, 16'hFFFF, "R7");
    bus_read(5'h0A, "R7");
    bus_write(5'h1E, 16'h0001, "R6");
    bus_read(5'h1E, "R6");
    bus_write(5'h08, 16'h00FF, "R7");
    bus_read(5'h08, "R7");

    // R8: bits beyond the pin count, odd and unmapped offsets
    bus_write(5'h1C, 16'hFFFF, "R8");
    bus_read(5'h1C, "R8");
    bus_write(5'h05, 16'hFFFF, "R8");
    bus_write(5'h10, 16'hFFFF, "R8");
    bus_read(5'h05, "R8");
    bus_read(5'h1F, "R8");

    // random traffic
    void'($urandom(32'd2024));
    for (int k = 0; k < 400; k++) begin
      logic [4:0]  a;
      logic [15:0] wd;
      int op;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: a = 5'h00; 1: a = 5'h02; 2: a = 5'h04; 3: a = 5'h06;
        4: a = 5'h08; 5: a = 5'h0A; 6: a = 5'h1C; 7: a = 5'h1E;
        default: a = 5'($urandom);
      endcase
      wd = 16'($urandom);
      op = $urandom_range(0, 4);
      if (op < 2)       bus_write(a, wd, "R3");
      else if (op < 4)  bus_read(a, tag_of(a));
      else set_pins({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule